// File: doc/BRIEF.md
# Dual-Bank Asynchronous SRAM Controller

This block connects a synchronous host request port to a byte-wide asynchronous static memory made of two equal banks. The two banks share one address bus, one data bus and one active-low output enable. Each bank has its own active-low bank enable and active-low write enable. The top bit of the host byte address chooses the bank. The remaining bits go out unchanged on the shared address lines.

A host holds `host_req` high with an address, a write flag and write data. It keeps them steady until `host_ready` pulses for one cycle. For a read, `host_rdata` is valid during that pulse. The controller times every phase in system clocks. The parameter `RD_WAIT` sets how long a read is held open. `WR_PULSE` sets the length of the write-enable pulse. `TURN_WAIT` sets how long a write whose previous access was a read keeps the data bus released after write enable falls, so that the memory's output drivers can let go of the bus. The data bus is presented as separate output, output-enable and input signals, so a pad ring or a bench can build the tri-state pin from them.

The sequencer has six states:
- `ST_IDLE`: both banks are in standby and no pin is driven.
- `ST_RD_ACC`: the chosen bank enable and the output enable are low.
- `ST_WR_TURN`: the bank enable and write enable are low, and the data bus is not yet driven.
- `ST_WR_PULSE`: the bank enable and write enable are low, and the data bus is driven.
- `ST_WR_END`: write enable is high, while the bank enable and the driven data are held.
- `ST_FINISH`: the ready pulse is raised and the bank enable is high.

The transitions are:
- `ST_IDLE` goes to `ST_RD_ACC` on a read request.
- `ST_IDLE` goes to `ST_WR_TURN` on a write request when a turnaround is pending, and to `ST_WR_PULSE` on a write request otherwise.
- `ST_RD_ACC`, `ST_WR_TURN` and `ST_WR_PULSE` each leave when their wait timer expires: to `ST_FINISH`, `ST_WR_PULSE` and `ST_WR_END` respectively.
- `ST_WR_END` always goes to `ST_FINISH`.
- `ST_FINISH` always goes to `ST_IDLE`.

Top module: `sram_dual_bank_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, both bank enables, both write enables and the output enable are high (1), `mem_dq_oe` is 0 and `host_ready` is 0. Reset also clears a pending turnaround, so the first write after reset takes no turnaround wait.
- R2: Host address bit 19 selects the bank. A value of 0 drives `mem_ce_n` to 2'b10 (bank 0), and 1 drives it to 2'b01 (bank 1). Host address bits 18:0 appear on `mem_addr`.
- R3: A read holds the chosen bank enable low, the output enable low and both write enables high for `RD_WAIT` cycles. It samples `mem_dq_i` at the last edge of that window and returns the sampled byte on `host_rdata`. `host_ready` is high in the cycle that follows the `RD_WAIT`-th clock edge after the edge that accepts the request.
- R4: A write with no pending turnaround holds the chosen bank's enable and write enable low, with data driven, for `WR_PULSE` cycles. It then raises write enable for one cycle with the bank still enabled. `host_ready` follows `WR_PULSE`+1 edges after the accepting edge. A write enable is low only together with its own bank enable.
- R5: A write whose previous completed access was a read first holds write enable low for `TURN_WAIT` cycles without driving data, and then carries on as in R4. Its latency is `TURN_WAIT`+`WR_PULSE`+1 edges.
- R6: `mem_dq_oe` is never 1 while `mem_oe_n` is 0, and the output enable stays high during every write.
- R7: `host_ready` is high for exactly one cycle per access, and both bank enables are high (standby) in that cycle and between accesses.
- R8: The two bank enables are never low at the same time.
- R9: While a bank is enabled, `mem_addr` and `mem_ce_n` do not change until that bank enable returns high.
- R10: Write data stays driven and unchanged from the first driven cycle through the cycle in which write enable rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Access request, held until `host_ready` |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 20 | Byte address; bit 19 selects the bank |
| host_wdata | input | 8 | Write data |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Read data, valid with `host_ready` after a read |
| mem_addr | output | 19 | Shared memory address lines |
| mem_ce_n | output | 2 | Active-low bank enables, one per bank |
| mem_we_n | output | 2 | Active-low write enables, one per bank |
| mem_oe_n | output | 1 | Shared active-low output enable |
| mem_dq_o | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | 1 = controller drives the data bus |
| mem_dq_i | input | 8 | Data returned from the memory bus |

## Verification
The request is accepted at one edge. From that edge, the ready pulse is due `RD_WAIT` edges later for a read, `WR_PULSE`+1 edges later for a plain write, and `TURN_WAIT`+`WR_PULSE`+1 edges later for a write that follows a read. The bench counts edges from the accepting edge, samples `host_ready` half a cycle after each edge, and compares the count with the value it computes from the parameters and from whether the previous access was a read. Its memory model drives valid read data only once the access has been open for `RD_WAIT` cycles, so a sample taken early returns a filler byte and fails the data check. The model commits a write only at the rising edge of write enable, and the stability checks on data, address and enables apply cycle by cycle at each sampled edge.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_WR_TURN,
        ST_WR_PULSE,
        ST_WR_END,
        ST_FINISH
    } seq_state_t;

    function automatic int max_of3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sram_bank_decode.sv
`timescale 1ns/1ps
module sram_bank_decode #(
    parameter int NUM_BANKS = 2,
    parameter int SEL_W     = 1
) (
    input  logic [SEL_W-1:0]     bank_sel,
    input  logic                 bank_act,
    input  logic                 we_act,
    output logic [NUM_BANKS-1:0] ce_n,
    output logic [NUM_BANKS-1:0] we_n
);

    // One decoded enable pair per bank; only the selected bank can go low.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit     = bank_act && (bank_sel == SEL_W'(b));
        assign ce_n[b] = ~hit;
        assign we_n[b] = ~(hit && we_act);
    end

endmodule

// File: rtl/sram_wait_timer.sv
`timescale 1ns/1ps
module sram_wait_timer #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int CW        = 2,
    parameter int RD_WAIT   = 3,
    parameter int WR_PULSE  = 2,
    parameter int TURN_WAIT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_we,
    input  logic          tmr_expired,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          capture,
    output logic          bank_act,
    output logic          we_act,
    output logic          oe_act,
    output logic          dq_drive,
    output logic          rd_capture,
    output logic          ready
);

    localparam logic [CW-1:0] RD_LOAD   = CW'(RD_WAIT - 1);
    localparam logic [CW-1:0] WR_LOAD   = CW'(WR_PULSE - 1);
    localparam logic [CW-1:0] TURN_LOAD = CW'(TURN_WAIT - 1);

    seq_state_t state_q, state_d;
    logic       turn_q, turn_d;

    // State register, including the pending-turnaround flag.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            turn_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            turn_q  <= turn_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        turn_d  = turn_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    if (req_we) begin
                        state_d = turn_q ? ST_WR_TURN : ST_WR_PULSE;
                        turn_d  = 1'b0;
                    end else begin
                        state_d = ST_RD_ACC;
                    end
                end
            end
            ST_RD_ACC: begin
                if (tmr_expired) begin
                    state_d = ST_FINISH;
                    turn_d  = 1'b1;
                end
            end
            ST_WR_TURN:  if (tmr_expired) state_d = ST_WR_PULSE;
            ST_WR_PULSE: if (tmr_expired) state_d = ST_WR_END;
            ST_WR_END:   state_d = ST_FINISH;
            ST_FINISH:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Output decode (Moore pins plus timer loads on transitions).
    always_comb begin
        tmr_load   = 1'b0;
        tmr_val    = '0;
        capture    = 1'b0;
        bank_act   = 1'b0;
        we_act     = 1'b0;
        oe_act     = 1'b0;
        dq_drive   = 1'b0;
        rd_capture = 1'b0;
        ready      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                capture  = req;
                tmr_load = req;
                if (!req_we)     tmr_val = RD_LOAD;
                else if (turn_q) tmr_val = TURN_LOAD;
                else             tmr_val = WR_LOAD;
            end
            ST_RD_ACC: begin
                bank_act   = 1'b1;
                oe_act     = 1'b1;
                rd_capture = tmr_expired;
            end
            ST_WR_TURN: begin
                bank_act = 1'b1;
                we_act   = 1'b1;
                tmr_load = tmr_expired;
                tmr_val  = WR_LOAD;
            end
            ST_WR_PULSE: begin
                bank_act = 1'b1;
                we_act   = 1'b1;
                dq_drive = 1'b1;
            end
            ST_WR_END: begin
                bank_act = 1'b1;
                dq_drive = 1'b1;
            end
            ST_FINISH: ready = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/sram_dual_bank_ctrl.sv
`timescale 1ns/1ps
module sram_dual_bank_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int BANK_AW   = 19,
    parameter int DW        = 8,
    parameter int RD_WAIT   = 3,
    parameter int WR_PULSE  = 2,
    parameter int TURN_WAIT = 2
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 host_req,
    input  logic                                 host_we,
    input  logic [BANK_AW+$clog2(NUM_BANKS)-1:0] host_addr,
    input  logic [DW-1:0]                        host_wdata,
    output logic                                 host_ready,
    output logic [DW-1:0]                        host_rdata,
    output logic [BANK_AW-1:0]                   mem_addr,
    output logic [NUM_BANKS-1:0]                 mem_ce_n,
    output logic [NUM_BANKS-1:0]                 mem_we_n,
    output logic                                 mem_oe_n,
    output logic [DW-1:0]                        mem_dq_o,
    output logic                                 mem_dq_oe,
    input  logic [DW-1:0]                        mem_dq_i
);

    localparam int SEL_W   = $clog2(NUM_BANKS);
    localparam int HOST_AW = BANK_AW + SEL_W;
    localparam int MAXW    = max_of3(RD_WAIT, WR_PULSE, TURN_WAIT);
    localparam int CW      = (MAXW < 2) ? 1 : $clog2(MAXW);

    logic [HOST_AW-1:0] addr_q;
    logic [DW-1:0]      wdata_q;
    logic [DW-1:0]      rdata_q;

    logic          tmr_load, tmr_expired;
    logic [CW-1:0] tmr_val;
    logic          capture, bank_act, we_act, oe_act, dq_drive, rd_capture;

    sram_seq_fsm #(
        .CW(CW), .RD_WAIT(RD_WAIT), .WR_PULSE(WR_PULSE), .TURN_WAIT(TURN_WAIT)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (host_req),
        .req_we     (host_we),
        .tmr_expired(tmr_expired),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .capture    (capture),
        .bank_act   (bank_act),
        .we_act     (we_act),
        .oe_act     (oe_act),
        .dq_drive   (dq_drive),
        .rd_capture (rd_capture),
        .ready      (host_ready)
    );

    sram_wait_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expired (tmr_expired)
    );

    sram_bank_decode #(.NUM_BANKS(NUM_BANKS), .SEL_W(SEL_W)) u_dec (
        .bank_sel(addr_q[HOST_AW-1:BANK_AW]),
        .bank_act(bank_act),
        .we_act  (we_act),
        .ce_n    (mem_ce_n),
        .we_n    (mem_we_n)
    );

    // Request capture: address and write data stay fixed for the access.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (capture) begin
            addr_q  <= host_addr;
            wdata_q <= host_wdata;
        end
    end

    // Read sampling at the end of the access window.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_capture) begin
            rdata_q <= mem_dq_i;
        end
    end

    assign mem_addr   = addr_q[BANK_AW-1:0];
    assign mem_oe_n   = ~oe_act;
    assign mem_dq_o   = wdata_q;
    assign mem_dq_oe  = dq_drive;
    assign host_rdata = rdata_q;

endmodule

// File: rtl/sram_ctrl_checker.sv
`timescale 1ns/1ps
module sram_ctrl_checker #(
    parameter int NUM_BANKS = 2,
    parameter int BANK_AW   = 19,
    parameter int DW        = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 host_ready,
    input logic [BANK_AW-1:0]   mem_addr,
    input logic [NUM_BANKS-1:0] mem_ce_n,
    input logic [NUM_BANKS-1:0] mem_we_n,
    input logic                 mem_oe_n,
    input logic [DW-1:0]        mem_dq_o,
    input logic                 mem_dq_oe
);

    assert_one_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~mem_ce_n) <= 1);

    assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    assert_read_we_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n == '1));

    assert_we_with_ce_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_n != '1) |-> (mem_we_n == mem_ce_n));

    assert_ready_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |=> !host_ready);

    assert_standby_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> (mem_ce_n == '1));

    assert_addr_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ce_n != '1) |=> (mem_ce_n == '1) || ($stable(mem_addr) && $stable(mem_ce_n)));

    assert_data_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && (mem_we_n != '1)) |=> (mem_dq_oe && $stable(mem_dq_o)));

endmodule

bind sram_dual_bank_ctrl sram_ctrl_checker #(
    .NUM_BANKS(NUM_BANKS), .BANK_AW(BANK_AW), .DW(DW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_ready(host_ready),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sim_sram_dual_bank_ctrl.sv
`timescale 1ns/1ps
module sim_sram_dual_bank_ctrl;

    localparam int RW = 3;
    localparam int WP = 2;
    localparam int TW = 2;
    localparam int NV = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [19:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_ready;
    logic [7:0]  host_rdata;
    logic [18:0] mem_addr;
    logic [1:0]  mem_ce_n, mem_we_n;
    logic        mem_oe_n;
    logic [7:0]  mem_dq_o;
    logic        mem_dq_oe;
    logic [7:0]  mem_dq_i;

    always #2.5 clk = ~clk;

    sram_dual_bank_ctrl #(.RD_WAIT(RW), .WR_PULSE(WP), .TURN_WAIT(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
        .host_rdata(host_rdata), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    // ---------------- behavioural two-bank memory model ----------------
    logic [7:0]  mem_model [512];
    logic [7:0]  gold [512];
    int          acc_cnt = 0;
    int          err_both = 0, err_contend = 0, err_hold = 0;
    int          undriven = 0;
    int          seen_bank = -1;
    logic [18:0] seen_addr = '0;
    int          mb;
    logic        wr_active = 1'b0, wr_has = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [8:0]  wr_idx = '0;
    logic        rd_now;

    assign rd_now = !mem_oe_n && ((mem_ce_n == 2'b10 && mem_we_n[0]) ||
                                  (mem_ce_n == 2'b01 && mem_we_n[1]));
    assign mem_dq_i = (rd_now && acc_cnt >= RW - 1) ?
                      mem_model[{~mem_ce_n[1], mem_addr[7:0]}] : 8'hEE;

    always @(posedge clk) begin
        mb = (mem_ce_n == 2'b10) ? 0 : (mem_ce_n == 2'b01) ? 1 : -1;
        if (mem_ce_n == 2'b00) err_both++;
        if (mem_dq_oe && !mem_oe_n) err_contend++;
        if (mb >= 0) begin
            seen_bank = mb;
            seen_addr = mem_addr;
        end
        if (rd_now) acc_cnt++;
        else        acc_cnt = 0;
        if (mb >= 0 && !mem_we_n[mb]) begin
            if (!mem_oe_n) err_contend++;
            if (wr_active && wr_has && mem_dq_oe && mem_dq_o != wr_data) err_hold++;
            wr_active = 1'b1;
            wr_idx    = {mb[0], mem_addr[7:0]};
            if (mem_dq_oe) begin
                wr_data = mem_dq_o;
                wr_has  = 1'b1;
            end else begin
                undriven++;
            end
        end else if (wr_active) begin
            if (mb >= 0 && (!mem_dq_oe || mem_dq_o != wr_data)) err_hold++;
            if (wr_has) mem_model[wr_idx] = wr_data;
            wr_active = 1'b0;
            wr_has    = 1'b0;
        end
    end

    // ---------------- checking infrastructure ----------------
    int total = 0, fails = 0;
    bit done = 1'b0;
    bit prev_read = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_access(input logic we, input logic [19:0] addr, input logic [7:0] wd);
        int n;
        int exp_lat;
        int exp_und;
        logic [8:0] idx;
        idx     = {addr[19], addr[7:0]};
        exp_und = (we && prev_read) ? TW : 0;
        exp_lat = we ? (exp_und + WP + 1) : RW;
        undriven  = 0;
        seen_bank = -1;
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_addr = addr; host_wdata = wd;
        @(posedge clk);
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end while (!host_ready && n < 40);
        host_req = 1'b0;
        if (!we)
            chk(n == exp_lat, "R3", "read latency", n, exp_lat);
        else if (exp_und != 0)
            chk(n == exp_lat, "R5", "turnaround write latency", n, exp_lat);
        else
            chk(n == exp_lat, "R4", "write latency", n, exp_lat);
        if (!we) chk(host_rdata == gold[idx], "R3", "read data", host_rdata, gold[idx]);
        else     gold[idx] = wd;
        chk(seen_bank == int'(addr[19]), "R2", "bank selected", seen_bank, addr[19]);
        chk(seen_addr == addr[18:0], "R2", "shared address", seen_addr, addr[18:0]);
        if (we) chk(undriven == exp_und, "R5", "undriven write cycles", undriven, exp_und);
        chk(mem_ce_n == 2'b11, "R7", "standby during ready", mem_ce_n, 3);
        @(negedge clk);
        chk(!host_ready, "R7", "ready single cycle", host_ready, 0);
        prev_read = !we;
    endtask

    // {write, address, write data}
    localparam logic [28:0] VEC [NV] = '{
        {1'b1, 20'h00012, 8'hA5},
        {1'b1, 20'h80012, 8'h5A},
        {1'b0, 20'h00012, 8'h00},
        {1'b0, 20'h80012, 8'h00},
        {1'b1, 20'h7FFFF, 8'hC3},
        {1'b1, 20'hFFFFF, 8'h3C},
        {1'b0, 20'hFFFFF, 8'h00},
        {1'b0, 20'h7FFFF, 8'h00},
        {1'b1, 20'h80012, 8'h99},
        {1'b0, 20'h00012, 8'h00},
        {1'b0, 20'h80012, 8'h00}
    };

    task automatic summary;
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) begin
            mem_model[i] = 8'h00;
            gold[i]      = 8'h00;
        end
        repeat (3) @(negedge clk);
        // R1: pins idle while in reset
        chk(mem_ce_n == 2'b11 && mem_we_n == 2'b11, "R1", "enables in reset",
            {mem_ce_n, mem_we_n}, 15);
        chk(mem_oe_n && !mem_dq_oe && !host_ready, "R1", "oe/dq/ready in reset",
            {mem_oe_n, mem_dq_oe, host_ready}, 4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_ce_n == 2'b11 && mem_oe_n && !mem_dq_oe, "R1", "idle after reset",
            {mem_ce_n, mem_oe_n, mem_dq_oe}, 14);

        for (int v = 0; v < NV; v++)
            run_access(VEC[v][28], VEC[v][27:8], VEC[v][7:0]);

        // R1: reset in the middle of a read returns pins to idle at once
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b0; host_addr = 20'h80012;
        @(posedge clk);
        @(negedge clk);
        host_req = 1'b0;
        chk(mem_ce_n == 2'b01, "R2", "bank 1 enabled mid read", mem_ce_n, 1);
        rst_n = 1'b0;
        #0.5;
        chk(mem_ce_n == 2'b11 && mem_oe_n && !host_ready, "R1", "abort to idle",
            {mem_ce_n, mem_oe_n, host_ready}, 14);
        @(negedge clk);
        rst_n = 1'b1;
        prev_read = 1'b0;
        // R1: turnaround flag cleared, so this write has no turnaround
        run_access(1'b1, 20'h00012, 8'h66);
        run_access(1'b0, 20'h00012, 8'h00);

        chk(err_both == 0, "R8", "both banks enabled", err_both, 0);
        chk(err_contend == 0, "R6", "bus contention", err_contend, 0);
        chk(err_hold == 0, "R10", "write data hold", err_hold, 0);
        chk(mem_model[9'h012] == 8'h66, "R4", "bank0 stored byte", mem_model[9'h012], 8'h66);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

endmodule